// File: doc/BRIEF.md
# Overlapping Serial 1101 Pattern Recognizer

This block watches a one-bit serial stream, taking one sample on every rising clock edge, and flags each place where the four most recent samples read 1, 1, 0, 1 in arrival order. The flag is combinational. It is raised during the cycle in which the closing 1 is present on the input, before the edge that samples it. Matches may share bits, so in the stream 1101101 the flag rises twice.

The machine has four states held in two flip-flops with a Gray-code assignment: idle 00, one '1' seen 01, two '1's seen 11, and "110" seen 10. The next-state and output logic are plain sum-of-products terms. After a match the machine moves to the one-'1' state, so the closing 1 can start the next occurrence. An asynchronous active-high reset returns the machine to idle and holds the flag low.

Top module: `overlap_match_fsm`

## Requirements
- R1: While `rst` is high, `matchOut` is 0, including when `rst` rises in the middle of a cycle. The machine restarts from the idle state.
- R2: `matchOut` is 1 during a cycle exactly when the three samples taken on the preceding edges, followed by the present `serialIn`, read 1, 1, 0, 1 (oldest first). At least three samples must have been taken since reset.
- R3: Overlapping occurrences are all reported. The stream 00111001101011011010011110111 (first bit leftmost) yields the per-cycle flag 00000000001000010010000000100.
- R4: `matchOut` follows `serialIn` within a cycle. After 1, 1, 0 has been sampled, the flag is 0 while `serialIn` is 0 and is 1 while `serialIn` is 1, with no clock edge in between.
- R5: Near misses such as 1001, 1111 and 1100 leave `matchOut` at 0.
- R6: Over a pseudo-random stream of 10,000 bits, `matchOut` agrees every cycle with a four-sample shift-register comparison against 1101.
- R7: A reset applied after a partial prefix (1, 1, 0) discards that history. A following 1 does not raise the flag, and a full new 1101 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that samples `serialIn` |
| rst | input | 1 | Asynchronous active-high reset to the idle state |
| serialIn | input | 1 | Serial data bit |
| matchOut | output | 1 | Combinational flag, high when the current bit completes 1101 |

## Verification
The hardest case to reach from the ports is the short window inside one cycle, with the machine in the "110" state, where the flag must follow the input level before any edge. The bench brings the machine there with a 1, 1, 0 prefix. It then toggles `serialIn` twice between two edges and samples the flag after each change. The same prefix is also used to assert reset mid-cycle, which shows the flag dropping at once without waiting for an edge and shows that the lost history is not carried over.

// File: rtl/omf_pkg.sv
package omf_pkg;
  localparam int STATE_W = 2;
  localparam int PATTERN_LEN = 4;

  typedef logic [STATE_W-1:0] stateCode_t;

  // Gray-code state assignment: high bit A, low bit B
  localparam stateCode_t ST_IDLE     = 2'b00;
  localparam stateCode_t ST_ONE      = 2'b01;
  localparam stateCode_t ST_ONEONE   = 2'b11;
  localparam stateCode_t ST_ONEONEZ  = 2'b10;

  // strobes from control to the state datapath
  typedef struct packed {
    logic loadHi;  // next value of bit A
    logic loadLo;  // next value of bit B
    logic hit;     // match flag for this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/omf_ctrl.sv
module omf_ctrl
  import omf_pkg::*;
(
  input  logic        rst,
  input  logic        serialIn,
  input  stateCode_t  stateQ,
  output ctrlStrobe_t strobes
);
  logic bitA;
  logic bitB;

  assign bitA = stateQ[STATE_W-1];
  assign bitB = stateQ[0];

  always_comb begin
    strobes        = '0;
    // sum-of-products next-state terms
    strobes.loadHi = (bitA & bitB) | (serialIn & bitB);
    strobes.loadLo = serialIn;
    // Mealy output: "110" seen and a 1 is present now
    strobes.hit    = serialIn & bitA & ~bitB & ~rst;
  end
endmodule

// File: rtl/omf_datapath.sv
module omf_datapath
  import omf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobes,
  output stateCode_t  stateQ,
  output logic        matchOut
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= {strobes.loadHi, strobes.loadLo};
    end
  end

  assign matchOut = strobes.hit;
endmodule

// File: rtl/overlap_match_fsm.sv
module overlap_match_fsm
  import omf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic matchOut
);
  stateCode_t  stateQ;
  ctrlStrobe_t strobes;

  omf_ctrl u_ctrl (
    .rst      (rst),
    .serialIn (serialIn),
    .stateQ   (stateQ),
    .strobes  (strobes)
  );

  omf_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .stateQ   (stateQ),
    .matchOut (matchOut)
  );
endmodule

// File: rtl/overlap_match_fsm_chk.sv
module overlap_match_fsm_chk
  import omf_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       serialIn,
  input logic       matchOut,
  input stateCode_t stateQ
);
  // R1: flag held low while reset is applied
  p_quiet_in_reset_r1: assert property (@(posedge clk) rst |-> !matchOut);

  // R2: a flag is only raised from the "110" state with a 1 present
  p_match_needs_prefix_r2: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> (stateQ == ST_ONEONEZ && serialIn));

  // R2: "110" state with a 1 present must raise the flag
  p_prefix_gives_match_r2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ONEONEZ && serialIn) |-> matchOut);

  // R3: after a match the closing 1 is kept as the start of the next one
  p_overlap_restart_r3: assert property (@(posedge clk) disable iff (rst)
    matchOut |=> stateQ == ST_ONE);

  // R5: a sampled 0 leaves only the idle or "110" state
  p_zero_lands_r5: assert property (@(posedge clk) disable iff (rst)
    !serialIn |=> (stateQ == ST_IDLE || stateQ == ST_ONEONEZ));

  // R5: "11" followed by 0 reaches the "110" state
  p_oneone_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ONEONE && !serialIn) |=> stateQ == ST_ONEONEZ);
endmodule

bind overlap_match_fsm overlap_match_fsm_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .serialIn (serialIn),
  .matchOut (matchOut),
  .stateQ   (stateQ)
);

// File: tb/sim_overlap_match_fsm.sv
module sim_overlap_match_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic matchOut;

  int checks = 0;
  int fails = 0;
  bit doneFlag = 1'b0;
  logic [3:0] hist = '0;
  int seen = 0;

  overlap_match_fsm u0 (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .matchOut (matchOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ends on a falling edge with reset released and the model cleared
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    serialIn = 1'b0;
    #2;
    check(matchOut == 1'b0, "R1 flag low in reset", int'(matchOut), 0);
    @(negedge clk);
    rst = 1'b0;
    hist = '0;
    seen = 0;
  endtask

  // called on a falling edge; drives one bit, checks before the rising edge
  task automatic stepBit(input logic b, input string tag, output logic zObs);
    logic expZ;
    serialIn = b;
    #5;
    expZ = (seen >= 3) && ({hist[2:0], b} == 4'b1101);
    zObs = matchOut;
    check(matchOut === expZ, tag, int'(matchOut), int'(expZ));
    hist = {hist[2:0], b};
    seen++;
    @(negedge clk);
  endtask

  initial begin : main
    logic zo;
    logic [28:0] vecIn;
    logic [28:0] vecOut;
    logic [31:0] lfsr;
    vecIn  = 29'b00111001101011011010011110111;
    vecOut = 29'b00000000001000010010000000100;

    #5;
    check(matchOut == 1'b0, "R1 flag low at start", int'(matchOut), 0);

    // R2: single occurrence
    doReset();
    stepBit(1'b1, "R2", zo);
    stepBit(1'b1, "R2", zo);
    stepBit(1'b0, "R2", zo);
    stepBit(1'b1, "R2", zo);
    check(zo == 1'b1, "R2 match on 1101", int'(zo), 1);

    // R5: near misses 1001, 1111, 1100
    doReset();
    foreach (vecIn[i]) begin
      if (i < 12) begin
        stepBit(logic'((12'b1001_1111_1100 >> i) & 1), "R5", zo);
      end
    end

    // R3: overlapping stream against stated flag vector
    doReset();
    for (int i = 28; i >= 0; i--) begin
      stepBit(vecIn[i], "R3 model", zo);
      check(zo == vecOut[i], "R3 vector", int'(zo), int'(vecOut[i]));
    end

    // R4: flag follows input inside one cycle
    doReset();
    stepBit(1'b1, "R4", zo);
    stepBit(1'b1, "R4", zo);
    stepBit(1'b0, "R4", zo);
    serialIn = 1'b0;
    #2;
    check(matchOut == 1'b0, "R4 input low", int'(matchOut), 0);
    serialIn = 1'b1;
    #2;
    check(matchOut == 1'b1, "R4 input high", int'(matchOut), 1);
    @(negedge clk);
    hist = {hist[2:0], 1'b1};
    seen++;
    stepBit(1'b1, "R4", zo);
    stepBit(1'b0, "R4", zo);
    stepBit(1'b1, "R4", zo);
    check(zo == 1'b1, "R4 overlap after in-cycle match", int'(zo), 1);

    // R7 and R1: mid-cycle reset discards a 110 prefix
    doReset();
    stepBit(1'b1, "R7", zo);
    stepBit(1'b1, "R7", zo);
    stepBit(1'b0, "R7", zo);
    serialIn = 1'b1;
    #2;
    check(matchOut == 1'b1, "R7 flag before reset", int'(matchOut), 1);
    rst = 1'b1;
    #2;
    check(matchOut == 1'b0, "R1 async drop", int'(matchOut), 0);
    @(negedge clk);
    rst = 1'b0;
    hist = '0;
    seen = 0;
    stepBit(1'b1, "R7", zo);
    check(zo == 1'b0, "R7 no stale match", int'(zo), 0);
    stepBit(1'b1, "R7", zo);
    stepBit(1'b0, "R7", zo);
    stepBit(1'b1, "R7", zo);
    check(zo == 1'b1, "R7 fresh match", int'(zo), 1);

    // R6: long pseudo-random stream
    doReset();
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 10000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      stepBit(lfsr[0], "R6", zo);
    end

    doneFlag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(20 * 150000);
    if (!doneFlag) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule